// File: doc/BRIEF.md
# Address Range Chip-Enable Decoder

This block is the address decode stage of a single-beat bus slave. An incoming address, qualified by a valid strobe, is compared against a parameter list of address ranges. Each range has a base and a high address. Every range that matches raises its own select line. Inside the matching range, the block raises one chip enable for the 32-bit word that the address falls in. Downstream register banks can use that enable directly as a per-register strobe.

Two bus modes exist:

- **Shared-bus mode.** Every range is compared in full. An address outside all ranges produces no hit.
- **Point-to-point mode.** If only one range is defined, the slave owns every address. The range comparison is skipped and only the word-index bits are decoded. If several ranges are defined, the full comparison stays in place so the ranges can still be told apart.

Each range has three legality rules. Its size must be a power of two. Its base must be aligned to that size. Its high address must close it exactly. Each chip-enable count must be a power of two and at least 1, and a range must span at least four bytes per chip enable. Any violation stops elaboration.

Top module: `addr_ce_decoder`

## Requirements
- R1: All outputs are registered. The result for an address presented with `addr_valid` high appears one clock later. A cycle with `addr_valid` low yields all outputs low on the next clock.
- R2: A synchronous active-high `rst` clears `range_sel`, `ce` and `hit` on the next clock, regardless of `addr_valid`.
- R3: In shared-bus mode, a valid address with base <= addr <= high for range r raises `range_sel[r]` and `hit`.
- R4: Within range r, chip enable i is raised for byte offsets 4*i to 4*i+3 from the base, in ascending order. The group of range r sits in `ce` starting at bit position equal to the sum of the chip-enable counts of ranges 0 to r-1.
- R5: A valid address inside range r whose byte offset is at or beyond 4 times its chip-enable count raises `range_sel[r]` and `hit` but no chip enable.
- R6: In shared-bus mode, a valid address outside every range leaves `range_sel`, `ce` and `hit` all low.
- R7: At most one bit of `ce` and at most one bit of `range_sel` is high in any cycle.
- R8: In point-to-point mode with one range, every valid address raises `range_sel[0]` and `hit`. The chip enable raised is the one selected by address bits [2 +: log2(count)], and no higher address bit affects the result.
- R9: In point-to-point mode with more than one range, decoding matches shared-bus mode exactly, including misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Qualifies `addr` for this cycle |
| addr | input | ADDR_W | Byte address |
| range_sel | output | NUM_RANGES | One select per matching range |
| ce | output | sum of CE_COUNTS | Per-word chip enables, groups packed in range order |
| hit | output | 1 | Some range matched |

## Verification
Every result of this block is due exactly one clock after the cycle in which its address and strobe were presented, including the cleared outputs after a reset cycle or an idle cycle. The driver applies each stimulus on a falling edge and queues its expected outputs at the same moment. The monitor pops one entry just after every following rising edge. Each comparison therefore lands in the single cycle where that stimulus's registered result is visible. Back-to-back addresses are checked against their own entries rather than a settled state.

// File: rtl/addr_ce_decoder.sv
module addr_ce_decoder #(
  parameter int NUM_RANGES = 2,
  parameter int ADDR_W = 32,
  parameter bit P2P = 1'b0,
  parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_BASE = {32'h0000_2000, 32'h0000_1000},
  parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_HIGH = {32'h0000_20FF, 32'h0000_100F},
  parameter logic [NUM_RANGES*16-1:0] CE_COUNTS = {16'd16, 16'd4}
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_RANGES-1:0] range_sel,
  output logic [ce_first(NUM_RANGES)-1:0] ce,
  output logic hit
);

  function automatic int ce_cnt(int r);
    return int'(CE_COUNTS[r*16 +: 16]);
  endfunction

  function automatic int ce_first(int r);
    int s = 0;
    for (int k = 0; k < r; k++) s += int'(CE_COUNTS[k*16 +: 16]);
    return s;
  endfunction

  function automatic bit range_ok(int r);
    logic [ADDR_W:0] b, h, sz, c;
    b = {1'b0, RANGE_BASE[r*ADDR_W +: ADDR_W]};
    h = {1'b0, RANGE_HIGH[r*ADDR_W +: ADDR_W]};
    c = (ADDR_W+1)'(ce_cnt(r));
    if (h < b) return 1'b0;
    sz = h - b + 1'b1;
    if ((sz & (sz - 1'b1)) != '0) return 1'b0;
    if ((b & (sz - 1'b1)) != '0) return 1'b0;
    if (c == '0 || (c & (c - 1'b1)) != '0) return 1'b0;
    if (sz < (c << 2)) return 1'b0;
    return 1'b1;
  endfunction

  localparam int TOTAL_CE = ce_first(NUM_RANGES);
  localparam bit P2P_ONE = P2P && (NUM_RANGES == 1);

  logic [NUM_RANGES-1:0] sel_d;
  logic [TOTAL_CE-1:0]   ce_d;

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    localparam logic [ADDR_W-1:0] BASE = RANGE_BASE[r*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HIGH = RANGE_HIGH[r*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] MASK = HIGH - BASE;
    localparam int CNT = ce_cnt(r);
    localparam int OFF = ce_first(r);

    if (!range_ok(r)) begin : g_bad
      $fatal(1, "addr_ce_decoder: range %0d has an illegal size, alignment or chip-enable count", r);
    end

    logic match, in_ce;
    logic [ADDR_W-1:0] woff;

    assign woff = (addr & MASK) >> 2;

    if (P2P_ONE) begin : g_p2p
      assign match = 1'b1;
      assign in_ce = 1'b1;
    end else begin : g_cmp
      assign match = (addr & ~MASK) == BASE;
      assign in_ce = woff < ADDR_W'(CNT);
    end

    assign sel_d[r] = match;

    for (genvar i = 0; i < CNT; i++) begin : g_ce
      assign ce_d[OFF+i] = match && in_ce && ((woff & ADDR_W'(CNT-1)) == ADDR_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      range_sel <= '0;
      ce        <= '0;
      hit       <= 1'b0;
    end else begin
      range_sel <= addr_valid ? sel_d : '0;
      ce        <= addr_valid ? ce_d : '0;
      hit       <= addr_valid && (|sel_d);
    end
  end

  assert_idle_clears_R1: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> (!hit && ce == '0 && range_sel == '0));

  assert_ce_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ce));

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(range_sel));

  assert_ce_needs_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (|ce) |-> (hit && (|range_sel)));

  if (P2P_ONE) begin : g_p2p_chk
    assert_p2p_always_hits_R8: assert property (@(posedge clk) disable iff (rst)
      addr_valid |=> (hit && $onehot(ce)));
  end

endmodule

// File: tb/addr_ce_decoder_tb.sv
module addr_ce_decoder_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_valid = 1'b0;
  logic [31:0] addr = '0;

  always #5 clk = ~clk;

  logic [1:0]  s_sel, m_sel;
  logic [19:0] s_ce, m_ce;
  logic        s_hit, m_hit;
  logic [0:0]  p_sel;
  logic [7:0]  p_ce;
  logic        p_hit;

  addr_ce_decoder u_dut (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr),
    .range_sel(s_sel), .ce(s_ce), .hit(s_hit));

  addr_ce_decoder #(.P2P(1'b1)) u_p2p_multi (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr),
    .range_sel(m_sel), .ce(m_ce), .hit(m_hit));

  addr_ce_decoder #(
    .NUM_RANGES(1), .P2P(1'b1),
    .RANGE_BASE(32'h0000_4000), .RANGE_HIGH(32'h0000_403F), .CE_COUNTS(16'd8)
  ) u_p2p_one (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr),
    .range_sel(p_sel), .ce(p_ce), .hit(p_hit));

  typedef struct {
    logic [1:0]  sel;
    logic [19:0] ce;
    logic        hit;
    logic [7:0]  pce;
    logic        phit;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic r, logic v, logic [31:0] a, string tag);
    exp_t e;
    @(negedge clk);
    rst = r; addr_valid = v; addr = a;
    e.sel = '0; e.ce = '0; e.hit = 1'b0; e.pce = '0; e.phit = 1'b0; e.tag = tag;
    if (!r && v) begin
      if (a >= 32'h1000 && a <= 32'h100F) begin
        e.sel[0] = 1'b1;
        e.ce[(a - 32'h1000) / 4] = 1'b1;
      end
      if (a >= 32'h2000 && a <= 32'h20FF) begin
        e.sel[1] = 1'b1;
        if (a - 32'h2000 < 64) e.ce[4 + (a - 32'h2000) / 4] = 1'b1;
      end
      e.hit = |e.sel;
      e.phit = 1'b1;
      e.pce[a[4:2]] = 1'b1;
    end
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "shared sel", 32'(s_sel), 32'(e.sel));
        chk(e.tag, "shared ce", 32'(s_ce), 32'(e.ce));
        chk(e.tag, "shared hit", 32'(s_hit), 32'(e.hit));
        chk({e.tag, " R9"}, "p2p multi sel/ce/hit", {9'b0, m_sel, m_ce, m_hit}, {9'b0, e.sel, e.ce, e.hit});
        chk({e.tag, " R8"}, "p2p one sel/ce/hit", {22'b0, p_sel, p_ce, p_hit}, {22'b0, e.phit, e.pce, e.phit});
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    drive(1'b1, 1'b0, 32'h0, "R2 reset");
    drive(1'b1, 1'b1, 32'h1000, "R2 reset with valid");
    drive(1'b0, 1'b0, 32'h1004, "R1 idle in range");
    for (int i = 0; i < 16; i++) drive(1'b0, 1'b1, 32'h1000 + 32'(i), "R3 R4 R7 range0 bytes");
    drive(1'b0, 1'b1, 32'h2000, "R4 range1 word0");
    drive(1'b0, 1'b1, 32'h2007, "R4 range1 word1");
    drive(1'b0, 1'b1, 32'h203C, "R4 R7 range1 word15");
    drive(1'b0, 1'b1, 32'h2040, "R5 beyond ce region");
    drive(1'b0, 1'b1, 32'h20FC, "R5 top of range1");
    drive(1'b0, 1'b1, 32'h20FF, "R3 R5 high address");
    drive(1'b0, 1'b1, 32'h0FFF, "R6 below range0");
    drive(1'b0, 1'b1, 32'h1010, "R6 above range0");
    drive(1'b0, 1'b1, 32'h1FFF, "R6 below range1");
    drive(1'b0, 1'b1, 32'h2100, "R6 above range1");
    drive(1'b0, 1'b1, 32'h0000_0000, "R6 zero");
    drive(1'b0, 1'b1, 32'hFFFF_2008, "R6 R8 aliased upper bits");
    drive(1'b0, 1'b1, 32'h0000_4014, "R6 R8 p2p word5");
    drive(1'b0, 1'b1, 32'h0000_101C, "R6 R8 p2p word7");
    drive(1'b0, 1'b0, 32'h2000, "R1 idle after hit");
    drive(1'b0, 1'b1, 32'h100C, "R1 R4 back to back a");
    drive(1'b0, 1'b1, 32'h2010, "R1 R4 back to back b");
    drive(1'b1, 1'b1, 32'h2010, "R2 reset mid run");
    drive(1'b0, 1'b1, 32'h1008, "R3 after reset");
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 32'h0, "R1 drain");
    wait (q.size() == 0);
    @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule